// File: doc/BRIEF.md
# Event-Driven PWM Generator

This block produces two pulse-width-modulated outputs from a single 16-bit down-counter. The counter counts down once per prescaled clock tick and reloads from a programmable period value when it reaches zero. Four counter events are recognised: the counter at zero, the counter at the period value, and a match with either of two compare values. For each output, a 12-bit action word tells the block what to do with that output when each event occurs: leave it, toggle it, force it low or force it high. Set-on-period, clear-on-compare gives classic edge-aligned PWM. Other settings give toggling clocks, shifted pulses and fixed levels.

Software configures the block through a small synchronous register port that uses byte addresses. A write takes effect at the next clock edge. Read data appears one cycle after the address is presented. A power-of-two prescaler sets the tick rate, and a global run bit freezes or restarts the counter. A per-output gate register forces each pin low when that output is not gated on.

Top module: `pwm_event_gen`

## Requirements
- R1: After a synchronous reset, every register reads back zero, the prescaler is bypassed and both pins are low.
- R2: While running, the counter decreases by one on every tick. On the tick where it is zero, it loads the period register (byte address 0x10). One period is therefore the period value plus one ticks.
- R3: Action codes are 0 for none, 1 for toggle, 2 for force low and 3 for force high. In an action word, bits 1:0 apply at zero, bits 3:2 at the period value, bits 7:6 at a compare-A match and bits 11:10 at a compare-B match. Output A uses the word at 0x20 and output B the word at 0x24.
- R4: Bits 5:4 and 9:8 of an action word are kept for readback but have no effect on either output.
- R5: When several events fall on the same tick, the non-zero action from the highest-ranked event wins. The ranking, lowest first, is zero, period, compare B, compare A.
- R6: A compare value (compare A at 0x18, compare B at 0x1C) that is greater than the period value never matches. Writes to the period and compare registers act from the next clock, with no wait for a period boundary.
- R7: The clock word at 0x28 has a use bit at bit 8 and a code in bits 2:0. With the use bit set, code c from 0 to 5 gives one tick every 2^(c+1) clocks, and codes 6 and 7 give one tick every 64 clocks. With the use bit clear, there is a tick on every clock.
- R8: Clearing the run bit (bit 0 at 0x00) freezes the counter and both output levels. Setting it from zero loads the counter with the period value, and counting resumes on the next tick.
- R9: The gate word at 0x2C enables pin A with bit 0 and pin B with bit 1. A pin whose bit is clear is held low. Pins are registered, so a pin follows its output level one clock later.
- R10: Register reads return data one clock after the address, masked to the implemented bits. Address 0x14 returns the live counter, and writes to it are ignored.
- R11: With the period action set high and the compare-A action set low, and a compare value C below period value L, pin A is high for L−C ticks and low for C+1 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register; bits 1:0 must be zero |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one clock after the address |
| pwm_a | output | 1 | Gated output A |
| pwm_b | output | 1 | Gated output B |

## Verification
The assertions assume that the bus address is word aligned, with the low two bits zero, and that the run bit is set from zero only by a write to the control register. The counter step and reload properties are written only for ticks that do not coincide with such a start write. The stimulus issues only aligned accesses, one per two clocks. It picks random period values in a small range with compare values below the period, so that every measured pulse sequence stays inside the watchdog window. Directed cases cover compare values above the period, a zero period, same-tick event collisions and all prescaler codes at the edges of the code range.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  // Action codes carried in each 2-bit field of an action word
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } act_e;

  // Counter events of one tick
  typedef struct packed {
    logic at_zero;
    logic at_load;
    logic cmpa;
    logic cmpb;
  } evt_t;

  // Action fields that are live in count-down mode
  typedef struct packed {
    act_e cmpa_dn;
    act_e cmpb_dn;
    act_e at_load;
    act_e at_zero;
  } act_live_t;

  localparam int ACT_W      = 12;
  localparam int CC_USE_BIT = 8;

  // Word indices (byte address / 4)
  localparam int WI_CTRL = 0;
  localparam int WI_LOAD = 4;
  localparam int WI_CNT  = 5;
  localparam int WI_CMPA = 6;
  localparam int WI_CMPB = 7;
  localparam int WI_ACT0 = 8;
  localparam int WI_CLK  = 10;
  localparam int WI_OE   = 11;

  // Ranked resolution: later checks override earlier ones
  function automatic act_e pick_action(act_live_t l, evt_t e);
    act_e r;
    r = ACT_NONE;
    if (e.at_zero && l.at_zero != ACT_NONE) r = l.at_zero;
    if (e.at_load && l.at_load != ACT_NONE) r = l.at_load;
    if (e.cmpb    && l.cmpb_dn != ACT_NONE) r = l.cmpb_dn;
    if (e.cmpa    && l.cmpa_dn != ACT_NONE) r = l.cmpa_dn;
    return r;
  endfunction

  function automatic logic apply_action(act_e a, logic cur);
    logic n;
    case (a)
      ACT_TOGGLE: n = ~cur;
      ACT_LOW:    n = 1'b0;
      ACT_HIGH:   n = 1'b1;
      default:    n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 6,
  parameter int DIV_W   = 3,
  parameter int NUM_OUT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CNT_W-1:0]         rdata,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic                     en_o,
  output logic                     start_o,
  output logic [CNT_W-1:0]         load_o,
  output logic [CNT_W-1:0]         cmpa_o,
  output logic [CNT_W-1:0]         cmpb_o,
  output act_live_t [NUM_OUT-1:0]  live_o,
  output logic                     use_o,
  output logic [DIV_W-1:0]         div_o,
  output logic [NUM_OUT-1:0]       oe_o
);

  localparam int WIDX_W = ADDR_W - 2;

  logic                            hit;
  logic [WIDX_W-1:0]               widx;
  logic                            en_q;
  logic [CNT_W-1:0]                load_q, cmpa_q, cmpb_q;
  logic [NUM_OUT-1:0][ACT_W-1:0]   act_q;
  logic                            use_q;
  logic [DIV_W-1:0]                div_q;
  logic [NUM_OUT-1:0]              oe_q;
  logic [CNT_W-1:0]                rd_next;

  assign hit  = (addr[1:0] == 2'b00);
  assign widx = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      load_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      act_q  <= '0;
      use_q  <= 1'b0;
      div_q  <= '0;
      oe_q   <= '0;
    end else if (we && hit) begin
      case (widx)
        WIDX_W'(WI_CTRL): en_q   <= wdata[0];
        WIDX_W'(WI_LOAD): load_q <= wdata;
        WIDX_W'(WI_CMPA): cmpa_q <= wdata;
        WIDX_W'(WI_CMPB): cmpb_q <= wdata;
        WIDX_W'(WI_CLK): begin
          use_q <= wdata[CC_USE_BIT];
          div_q <= wdata[DIV_W-1:0];
        end
        WIDX_W'(WI_OE):   oe_q   <= wdata[NUM_OUT-1:0];
        default: ;
      endcase
      for (int i = 0; i < NUM_OUT; i++) begin
        if (widx == WIDX_W'(WI_ACT0 + i)) act_q[i] <= wdata[ACT_W-1:0];
      end
    end
  end

  // Run bit rising by a write: counter restarts from the period value
  assign start_o = we && hit && (widx == WIDX_W'(WI_CTRL)) && wdata[0] && !en_q;

  always_comb begin
    rd_next = '0;
    if (hit) begin
      case (widx)
        WIDX_W'(WI_CTRL): rd_next[0] = en_q;
        WIDX_W'(WI_LOAD): rd_next = load_q;
        WIDX_W'(WI_CNT):  rd_next = cnt_i;
        WIDX_W'(WI_CMPA): rd_next = cmpa_q;
        WIDX_W'(WI_CMPB): rd_next = cmpb_q;
        WIDX_W'(WI_CLK): begin
          rd_next[CC_USE_BIT]  = use_q;
          rd_next[DIV_W-1:0]   = div_q;
        end
        WIDX_W'(WI_OE):   rd_next[NUM_OUT-1:0] = oe_q;
        default: ;
      endcase
      for (int i = 0; i < NUM_OUT; i++) begin
        if (widx == WIDX_W'(WI_ACT0 + i)) rd_next[ACT_W-1:0] = act_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_live
      assign live_o[g].at_zero = act_e'(act_q[g][1:0]);
      assign live_o[g].at_load = act_e'(act_q[g][3:2]);
      assign live_o[g].cmpa_dn = act_e'(act_q[g][7:6]);
      assign live_o[g].cmpb_dn = act_e'(act_q[g][11:10]);
    end
  endgenerate

  assign en_o   = en_q;
  assign load_o = load_q;
  assign cmpa_o = cmpa_q;
  assign cmpb_o = cmpb_q;
  assign use_o  = use_q;
  assign div_o  = div_q;
  assign oe_o   = oe_q;

  // R10: a write to the counter address leaves the period register alone
  assert_cnt_wr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (we && hit && widx == WIDX_W'(WI_CNT)) |=> (load_q == $past(load_q)));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W    = 3,
  parameter int LOG2_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             tick_o
);

  localparam int MW = LOG2_MAX + 1;

  logic [LOG2_MAX-1:0] pcnt;
  logic [MW-1:0]       mask_w;
  logic [LOG2_MAX-1:0] mask;
  int                  k;

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else     pcnt <= pcnt + LOG2_MAX'(1);
  end

  // Power-of-two divide: tick when all selected low bits are ones
  always_comb begin
    if (int'(code_i) >= LOG2_MAX - 1) k = LOG2_MAX;
    else                              k = int'(code_i) + 1;
    mask_w = (MW'(1) << k) - MW'(1);
    mask   = mask_w[LOG2_MAX-1:0];
  end

  assign tick_o = !use_i || ((pcnt & mask) == mask);

  // R7: with the divider in use, ticks are never on consecutive clocks
  assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
    (use_i && tick_o) |=> (!use_i || !tick_o));

endmodule

// File: rtl/pwm_downcnt.sv
module pwm_downcnt
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] cnt_o,
  output evt_t             evt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = en_i && tick_i;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (start_i)     cnt_q <= load_i;
    else if (active) begin
      if (cnt_q == '0)    cnt_q <= load_i;
      else                cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    evt_o.at_zero = active && (cnt_q == '0);
    evt_o.at_load = active && (cnt_q == load_i);
    evt_o.cmpa    = active && (cmpa_i <= load_i) && (cnt_q == cmpa_i);
    evt_o.cmpb    = active && (cmpb_i <= load_i) && (cnt_q == cmpb_i);
  end

  assign cnt_o = cnt_q;

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i && !start_i && cnt_q == '0) |=> (cnt_q == $past(load_i)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !start_i) |=> $stable(cnt_q));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == $past(load_i)));

  assert_cmp_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_o.cmpa || evt_o.cmpb) |-> (cnt_q <= load_i));

endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen
  import pwm_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  evt_t      evt_i,
  input  act_live_t live_i,
  output logic      level_o
);

  act_e sel;
  logic lvl_q;

  assign sel = pick_action(live_i, evt_i);

  always_ff @(posedge clk) begin
    if (rst)                  lvl_q <= 1'b0;
    else if (sel != ACT_NONE) lvl_q <= apply_action(sel, lvl_q);
  end

  assign level_o = lvl_q;

  // R8: with no event (frozen or between events) the level holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0) |=> $stable(lvl_q));

  // R5: a compare-A action, when non-zero, decides the level
  assert_cmpa_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_i.cmpa && live_i.cmpa_dn == ACT_HIGH) |=> lvl_q);

endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 6,
  parameter int DIV_W    = 3,
  parameter int LOG2_MAX = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int NUM_OUT = 2;

  logic                      en, start, use_div, tick;
  logic [DIV_W-1:0]          div_code;
  logic [CNT_W-1:0]          load_v, cmpa_v, cmpb_v, cnt_v;
  act_live_t [NUM_OUT-1:0]   live;
  logic [NUM_OUT-1:0]        oe, lvl, pin_q;
  evt_t                      evt;

  pwm_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .NUM_OUT(NUM_OUT)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .cnt_i(cnt_v), .en_o(en), .start_o(start),
    .load_o(load_v), .cmpa_o(cmpa_v), .cmpb_o(cmpb_v), .live_o(live),
    .use_o(use_div), .div_o(div_code), .oe_o(oe)
  );

  pwm_prescale #(.DIV_W(DIV_W), .LOG2_MAX(LOG2_MAX)) u_pre (
    .clk(clk), .rst(rst), .use_i(use_div), .code_i(div_code), .tick_o(tick)
  );

  pwm_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .start_i(start), .tick_i(tick),
    .load_i(load_v), .cmpa_i(cmpa_v), .cmpb_i(cmpb_v),
    .cnt_o(cnt_v), .evt_o(evt)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_out
      pwm_outgen u_gen (
        .clk(clk), .rst(rst), .evt_i(evt), .live_i(live[g]), .level_o(lvl[g])
      );

      always_ff @(posedge clk) begin
        if (rst) pin_q[g] <= 1'b0;
        else     pin_q[g] <= lvl[g] & oe[g];
      end

      assert_gate_low_R9: assert property (@(posedge clk) disable iff (rst)
        !oe[g] |=> !pin_q[g]);
    end
  endgenerate

  assign pwm_a = pin_q[0];
  assign pwm_b = pin_q[1];

endmodule

// File: tb/pwm_event_gen_bench.sv
`timescale 1ns/1ps
module pwm_event_gen_bench;

  localparam logic [5:0] A_CTRL = 6'h00, A_LOAD = 6'h10, A_CNT = 6'h14,
                         A_CMPA = 6'h18, A_CMPB = 6'h1C, A_ACTA = 6'h20,
                         A_ACTB = 6'h24, A_CLK  = 6'h28, A_OE   = 6'h2C;
  localparam int LIMIT = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_a, pwm_b;

  int nchecks = 0;
  int nerrs   = 0;

  pwm_event_gen u_pwm_event_gen (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  function automatic logic pin(input int sel);
    return (sel == 0) ? pwm_a : pwm_b;
  endfunction

  task automatic wait_rise(input int sel, output bit ok);
    logic prev, cur;
    int guard;
    ok = 1'b0; guard = 0;
    prev = pin(sel);
    while (guard < LIMIT) begin
      @(negedge clk);
      cur = pin(sel);
      guard++;
      if (!prev && cur) begin ok = 1'b1; break; end
      prev = cur;
    end
  endtask

  // Cycles high then low after a clean rising edge
  task automatic measure(input int sel, output int hi, output int lo);
    bit ok1, ok2;
    wait_rise(sel, ok1);
    wait_rise(sel, ok2);
    hi = -1; lo = -1;
    if (ok1 && ok2) begin
      hi = 1;
      forever begin
        @(negedge clk);
        if (pin(sel) && hi < LIMIT) hi++; else break;
      end
      lo = 1;
      forever begin
        @(negedge clk);
        if (!pin(sel) && lo < LIMIT) lo++; else break;
      end
    end
  endtask

  task automatic hold_check(input int sel, input logic lvl, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin(sel) !== lvl) bad++;
    end
  endtask

  function automatic int div_of(input int code);
    return 1 << (((code > 5) ? 5 : code) + 1);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerrs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin : main
    int v, v2, hi, lo, bad, L, C;
    logic lvl;
    logic [5:0] addrs [9];
    logic [15:0] r_load, r_cmpa, r_cmpb, r_acta, r_actb, r_clk;
    int codes [5];

    v = int'($urandom(32'h5EED_1234));
    addrs = '{A_CTRL, A_LOAD, A_CNT, A_CMPA, A_CMPB, A_ACTA, A_ACTB, A_CLK, A_OE};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    foreach (addrs[i]) begin
      rd(addrs[i], v);
      check("R1", $sformatf("reset read of 0x%0h", addrs[i]), v, 0);
    end
    check("R1", "pin A after reset", int'(pwm_a), 0);
    check("R1", "pin B after reset", int'(pwm_b), 0);

    // R10: readback with masking; counter address is read-only
    r_load = 16'($urandom); r_cmpa = 16'($urandom); r_cmpb = 16'($urandom);
    r_acta = 16'($urandom); r_actb = 16'($urandom); r_clk = 16'($urandom);
    wr(A_LOAD, r_load); wr(A_CMPA, r_cmpa); wr(A_CMPB, r_cmpb);
    wr(A_ACTA, r_acta); wr(A_ACTB, r_actb); wr(A_CLK, r_clk); wr(A_OE, 16'hFFFF);
    rd(A_LOAD, v); check("R10", "period readback", v, int'(r_load));
    rd(A_CMPA, v); check("R10", "compare A readback", v, int'(r_cmpa));
    rd(A_CMPB, v); check("R10", "compare B readback", v, int'(r_cmpb));
    rd(A_ACTA, v); check("R10", "action A readback", v, int'(r_acta & 16'h0FFF));
    rd(A_ACTB, v); check("R10", "action B readback", v, int'(r_actb & 16'h0FFF));
    rd(A_CLK, v);  check("R10", "clock word readback", v, int'(r_clk & 16'h0107));
    rd(A_OE, v);   check("R10", "gate readback", v, 3);
    wr(A_CNT, 16'hBEEF);
    rd(A_CNT, v);  check("R10", "counter write ignored", v, 0);
    rd(A_LOAD, v); check("R10", "period untouched by counter write", v, int'(r_load));

    // R11, R2: edge-aligned PWM, L=9 C=3
    wr(A_CLK, 16'h0000); wr(A_OE, 16'h0003);
    wr(A_LOAD, 16'd9); wr(A_CMPA, 16'd3); wr(A_CMPB, 16'd0);
    wr(A_ACTA, 16'h008C); wr(A_ACTB, 16'h0000);
    wr(A_CTRL, 16'h0001);
    measure(0, hi, lo);
    check("R11", "high ticks L=9 C=3", hi, 6);
    check("R11", "low ticks L=9 C=3", lo, 4);
    check("R2", "period ticks L=9", hi + lo, 10);

    // R3: toggle on period, zero/period, zero/compare-B
    wr(A_ACTB, 16'h0004);
    measure(1, hi, lo);
    check("R3", "toggle on period high", hi, 10);
    check("R3", "toggle on period low", lo, 10);
    wr(A_ACTB, 16'h000B);
    measure(1, hi, lo);
    check("R3", "high at zero low at period: high", hi, 1);
    check("R3", "high at zero low at period: low", lo, 9);
    wr(A_CMPB, 16'd4); wr(A_ACTB, 16'h0803);
    measure(1, hi, lo);
    check("R3", "high at zero low at compare B: high", hi, 6);
    check("R3", "high at zero low at compare B: low", lo, 4);

    // R4: up-count fields ask for low but have no effect
    wr(A_CMPA, 16'd3); wr(A_CMPB, 16'd5); wr(A_ACTA, 16'h022C);
    repeat (25) @(negedge clk);
    hold_check(0, 1'b1, 40, bad);
    check("R4", "up-count fields ignored (mismatching cycles)", bad, 0);

    // R5: same-tick priority
    wr(A_LOAD, 16'd5); wr(A_CMPA, 16'd5); wr(A_CMPB, 16'd5);
    wr(A_ACTA, 16'h0848);
    measure(0, hi, lo);
    check("R5", "compare A toggle beats B and period: high", hi, 6);
    check("R5", "compare A toggle beats B and period: low", lo, 6);
    wr(A_ACTB, 16'h0C0A);
    measure(1, hi, lo);
    check("R5", "compare B beats period: high", hi, 5);
    check("R5", "compare B beats period: low", lo, 1);
    wr(A_LOAD, 16'd0); wr(A_ACTA, 16'h000B);
    repeat (4) @(negedge clk);
    hold_check(0, 1'b0, 20, bad);
    check("R5", "period low beats zero high (mismatching cycles)", bad, 0);
    wr(A_ACTA, 16'h000E);
    repeat (4) @(negedge clk);
    hold_check(0, 1'b1, 20, bad);
    check("R5", "period high beats zero low (mismatching cycles)", bad, 0);

    // R6: compare above period never matches; writes act immediately
    wr(A_LOAD, 16'd7); wr(A_CMPA, 16'd20); wr(A_ACTA, 16'h008C);
    repeat (20) @(negedge clk);
    hold_check(0, 1'b1, 40, bad);
    check("R6", "compare above period no match (mismatching cycles)", bad, 0);
    wr(A_CMPA, 16'd2);
    measure(0, hi, lo);
    check("R6", "new compare in effect: high", hi, 5);
    check("R6", "new compare in effect: low", lo, 3);

    // R7: prescaler, toggle on period with L=3
    wr(A_LOAD, 16'd3); wr(A_ACTA, 16'h0004);
    codes = '{0, 2, 5, 6, 7};
    foreach (codes[i]) begin
      wr(A_CLK, 16'h0100 | 16'(codes[i]));
      measure(0, hi, lo);
      check("R7", $sformatf("code %0d high", codes[i]), hi, 4 * div_of(codes[i]));
      check("R7", $sformatf("code %0d low", codes[i]), lo, 4 * div_of(codes[i]));
    end
    wr(A_CLK, 16'h0005);
    measure(0, hi, lo);
    check("R7", "use bit clear bypasses divider", hi, 4);

    // R8: freeze and restart
    wr(A_LOAD, 16'd9); wr(A_CMPA, 16'd3); wr(A_ACTA, 16'h008C);
    repeat (15) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    rd(A_CNT, v);
    lvl = pwm_a;
    hold_check(0, lvl, 20, bad);
    rd(A_CNT, v2);
    check("R8", "counter frozen while stopped", v2, v);
    check("R8", "pin A held while stopped (mismatching cycles)", bad, 0);
    wr(A_CTRL, 16'h0001);
    rd(A_CNT, v);
    check("R8", "restart from period value", v, 8);

    // R9: gating
    wr(A_ACTB, 16'h0004); wr(A_OE, 16'h0002);
    repeat (2) @(negedge clk);
    hold_check(0, 1'b0, 30, bad);
    check("R9", "pin A held low when gated off (mismatching cycles)", bad, 0);
    measure(1, hi, lo);
    check("R9", "pin B still runs", hi, 10);
    wr(A_OE, 16'h0003);

    // R11: random period and compare
    for (int it = 0; it < 8; it++) begin
      L = int'($urandom_range(40, 2));
      C = int'($urandom_range(L - 1, 0));
      wr(A_CMPA, 16'(C)); wr(A_LOAD, 16'(L));
      measure(0, hi, lo);
      check("R11", $sformatf("random L=%0d C=%0d high", L, C), hi, L - C);
      check("R11", $sformatf("random L=%0d C=%0d low", L, C), lo, C + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule